// File: doc/BRIEF.md
# Dual-Mode Parallel Host Port

This block is the parallel bus slave that sits between a host processor and a display controller's internals. It accepts the two common asynchronous strobe conventions: a write/read strobe pair or a read-not-write level with an enable pulse. Both work at a 16-bit or an 8-bit bus width. Bus pins are brought into the internal clock domain. Each completed host cycle becomes exactly one internal event. Byte-wide transfers are assembled into 16-bit pixel words.

Writes leave the block on two valid/ready streams. Control bytes go to the command decoder and pixel words go toward display memory. Reads of display memory pass through a two-stage path: a fetch request stream plus a holding latch that the response fills. Because of that latch, the first data read after any address change returns the word fetched earlier and must be discarded by the host. The command decoder signals address changes on a single pulse input.

The host bus cannot be stalled. The streams are therefore one-deep: a transfer waits with valid held until ready, and the host must pace its cycles so the previous transfer has been taken. The memory response carries no ready and is always accepted.

Top module: `hpb_port`

## Requirements
- R1: With `cfg_mode68`=0, a low level on `bus_stb0` is a write strobe and a low level on `bus_stb1` is a read strobe.
- R2: With `cfg_mode68`=1, `bus_stb1` high is the enable pulse and `bus_stb0` gives the direction during it (1 read, 0 write).
- R3: A cycle is accepted only while `bus_cs_a_n` is 0 and `bus_cs_b` is 1; a strobe with either select inactive changes no output.
- R4: After reset all stream valids and `bus_oe` are 0. Each host cycle produces one transfer, taken when its strobe is released, with the bus data held at least three clocks past release.
- R5: With `cfg_wide`=1 a data write (`bus_cd`=1) yields one pixel word equal to `bus_din`. With `cfg_wide`=0 the first byte on `bus_din[7:0]` becomes bits 15:8 and the second becomes bits 7:0 of one pixel word; `bus_din[15:8]` is ignored.
- R6: A control write (`bus_cd`=0) presents `bus_din[7:0]` on `cmd_data` with `cmd_valid` high, in either width.
- R7: The byte phase returns to the high byte on an `addr_upd` pulse and on any control cycle.
- R8: `cmd_valid`/`pix_valid` and their data hold until the matching ready is high. A new write of the same kind that arrives while the previous one is pending and not accepted that cycle is dropped.
- R9: A data read drives the latched word and then requests a fetch whose response replaces it. The first data read after `addr_upd` drives the stale latch, issues a fetch and does not advance the byte phase.
- R10: With `cfg_wide`=0, a primed data read drives the latch's high byte and then its low byte on bits 7:0, with bits 15:8 zero. Only the low-byte read issues a fetch.
- R11: `bus_oe` is 1 only while selected with a read strobe active. A control read drives zero and issues no fetch.
- R12: `rd_req_valid` holds until `rd_req_ready`. A `rd_rsp_valid` cycle loads the read latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode68 | input | 1 | 0: write/read strobe pair, 1: direction level plus enable |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus on bits 7:0 |
| bus_cs_a_n | input | 1 | Chip select, active low |
| bus_cs_b | input | 1 | Chip select, active high |
| bus_cd | input | 1 | 0 control, 1 display data |
| bus_stb0 | input | 1 | Write strobe (low) or direction level |
| bus_stb1 | input | 1 | Read strobe (low) or enable (high) |
| bus_din | input | 16 | Data from host |
| bus_dq_o | output | 16 | Read data toward the pads |
| bus_oe | output | 1 | Pad drive enable; pads float when 0 |
| addr_upd | input | 1 | Pulse: a column or row address was just set |
| cmd_valid | output | 1 | Control byte available |
| cmd_ready | input | 1 | Control byte taken |
| cmd_data | output | 8 | Control byte |
| pix_valid | output | 1 | Pixel word available |
| pix_ready | input | 1 | Pixel word taken |
| pix_data | output | 16 | Pixel word |
| rd_req_valid | output | 1 | Fetch request to display memory |
| rd_req_ready | input | 1 | Fetch request taken |
| rd_rsp_valid | input | 1 | Fetched word present |
| rd_rsp_data | input | 16 | Fetched word |

## Verification
The bench aims at the dummy read after an address change. A design that skipped it would return the fresh word one read early and shift every later pixel. In byte mode it checks that the phase restarts after a control cycle or an address pulse. Without that restart the bytes pair up wrongly, for example 0x2211 instead of 0x1122. It also writes twice without a ready and reads with the fetch request held off. A stream that overwrote, or a request that dropped, would lose or corrupt a word. Deselected strobes and control reads are checked for no fetch and no transfer.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [BUS_W-1:0]  word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic cd;
  } bus_ev_t;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpb_decode.sv
module hpb_decode
  import hpb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode68,
  input  logic    cs_a_n,
  input  logic    cs_b,
  input  logic    stb0,
  input  logic    stb1,
  input  logic    cd,
  input  word_t   din,
  output bus_ev_t ev,
  output word_t   din_q
);
  localparam int NPIN = 5;
  // idle: cs_a_n=1, cs_b=0, stb0=1, stb1=1, cd=0 -> not selected
  localparam logic [NPIN-1:0] PIN_IDLE = 5'b10110;

  logic [NPIN-1:0] raw, syn;
  assign raw = {cs_a_n, cs_b, stb0, stb1, cd};

  hpb_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  logic s_csa_n, s_csb, s_stb0, s_stb1, s_cd;
  assign {s_csa_n, s_csb, s_stb0, s_stb1, s_cd} = syn;

  logic sel, wr_act, rd_act, wr_prev, rd_prev, cd_q;
  assign sel    = !s_csa_n && s_csb;
  assign wr_act = sel && (mode68 ? (s_stb1 && !s_stb0) : !s_stb0);
  assign rd_act = sel && (mode68 ? (s_stb1 &&  s_stb0) : !s_stb1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
      cd_q    <= 1'b0;
      din_q   <= '0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
      if (wr_act || rd_act) cd_q  <= s_cd;
      if (wr_act)           din_q <= din;
    end
  end

  // transfer completes on the synchronised release of the strobe
  assign ev.wr = wr_prev && !wr_act;
  assign ev.rd = rd_prev && !rd_act;
  assign ev.cd = cd_q;
endmodule

// File: rtl/hpb_wr_path.sv
module hpb_wr_path
  import hpb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wide,
  input  phase_e phase,
  input  logic   ev_wr,
  input  logic   ev_cd,
  input  word_t  din_q,
  input  logic   cmd_ready,
  input  logic   pix_ready,
  output logic   cmd_valid,
  output byte_t  cmd_data,
  output logic   pix_valid,
  output word_t  pix_data,
  output logic   adv
);
  logic  data_ev, cmd_ev, pix_emit;
  byte_t hi_q;
  word_t pix_word;

  assign data_ev  = ev_wr && ev_cd;
  assign cmd_ev   = ev_wr && !ev_cd;
  assign pix_emit = data_ev && (wide || phase == PH_LO);
  assign pix_word = wide ? din_q : {hi_q, din_q[BYTE_W-1:0]};
  assign adv      = data_ev && !wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (data_ev && !wide && phase == PH_HI) hi_q <= din_q[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (cmd_ev && !(cmd_valid && !cmd_ready)) begin
        cmd_valid <= 1'b1;
        cmd_data  <= din_q[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      if (pix_valid && pix_ready) pix_valid <= 1'b0;
      if (pix_emit && !(pix_valid && !pix_ready)) begin
        pix_valid <= 1'b1;
        pix_data  <= pix_word;
      end
    end
  end
endmodule

// File: rtl/hpb_rd_path.sv
module hpb_rd_path
  import hpb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wide,
  input  phase_e phase,
  input  logic   ev_rd,
  input  logic   ev_cd,
  input  logic   addr_upd,
  input  logic   req_ready,
  input  logic   rsp_valid,
  input  word_t  rsp_data,
  output logic   req_valid,
  output word_t  drive_word,
  output logic   adv
);
  logic  primed_q, data_ev, fetch;
  word_t latch_q;
  byte_t lane;

  assign data_ev = ev_rd && ev_cd && !addr_upd;
  assign fetch   = data_ev && (!primed_q || wide || phase == PH_LO);
  assign adv     = data_ev && primed_q && !wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      req_valid <= 1'b0;
      latch_q   <= '0;
    end else begin
      if (addr_upd)     primed_q <= 1'b0;
      else if (data_ev) primed_q <= 1'b1;

      if (fetch)          req_valid <= 1'b1;
      else if (req_ready) req_valid <= 1'b0;

      if (rsp_valid) latch_q <= rsp_data;
    end
  end

  assign lane       = (phase == PH_HI) ? latch_q[BUS_W-1 -: BYTE_W] : latch_q[BYTE_W-1:0];
  assign drive_word = wide ? latch_q : {{(BUS_W-BYTE_W){1'b0}}, lane};
endmodule

// File: rtl/hpb_port.sv
module hpb_port
  import hpb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode68,
  input  logic              cfg_wide,
  input  logic              bus_cs_a_n,
  input  logic              bus_cs_b,
  input  logic              bus_cd,
  input  logic              bus_stb0,
  input  logic              bus_stb1,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dq_o,
  output logic              bus_oe,
  input  logic              addr_upd,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [BUS_W-1:0]  pix_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [BUS_W-1:0]  rd_rsp_data
);
  bus_ev_t ev;
  word_t   din_q, drive_word;
  phase_e  phase_q;
  logic    wr_adv, rd_adv, ev_wr_w, ev_rd_w;

  hpb_decode #(.SYNC_STAGES(SYNC_STAGES)) u_decode (
    .clk(clk), .rst_n(rst_n), .mode68(cfg_mode68),
    .cs_a_n(bus_cs_a_n), .cs_b(bus_cs_b), .stb0(bus_stb0), .stb1(bus_stb1),
    .cd(bus_cd), .din(bus_din), .ev(ev), .din_q(din_q)
  );

  assign ev_wr_w = ev.wr;
  assign ev_rd_w = ev.rd;

  // byte phase shared by both directions; control cycles and address updates restart it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          phase_q <= PH_HI;
    else if (addr_upd)                   phase_q <= PH_HI;
    else if ((ev.wr || ev.rd) && !ev.cd) phase_q <= PH_HI;
    else if (wr_adv || rd_adv)           phase_q <= (phase_q == PH_HI) ? PH_LO : PH_HI;
  end

  hpb_wr_path u_wr (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .phase(phase_q),
    .ev_wr(ev.wr), .ev_cd(ev.cd), .din_q(din_q),
    .cmd_ready(cmd_ready), .pix_ready(pix_ready),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .adv(wr_adv)
  );

  hpb_rd_path u_rd (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .phase(phase_q),
    .ev_rd(ev.rd), .ev_cd(ev.cd), .addr_upd(addr_upd),
    .req_ready(rd_req_ready), .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .req_valid(rd_req_valid), .drive_word(drive_word), .adv(rd_adv)
  );

  // pad drive follows the raw pins so data is present for the whole strobe
  logic sel_raw, rd_raw;
  assign sel_raw  = !bus_cs_a_n && bus_cs_b;
  assign rd_raw   = cfg_mode68 ? (bus_stb1 && bus_stb0) : !bus_stb1;
  assign bus_oe   = sel_raw && rd_raw;
  assign bus_dq_o = bus_cd ? drive_word : '0;
endmodule

// File: rtl/hpb_port_chk.sv
module hpb_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_upd,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_data,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [15:0] pix_data,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic        ev_wr,
  input logic        ev_rd
);
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid);

  p_wr_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !ev_wr);

  p_rd_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> !ev_rd);

  p_upd_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_upd |=> !$rose(rd_req_valid));
endmodule

bind hpb_port hpb_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_upd(addr_upd),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .ev_wr(ev_wr_w), .ev_rd(ev_rd_w)
);

// File: tb/hpb_port_bench.sv
module hpb_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_mode68 = 1'b0, cfg_wide = 1'b1;
  logic cs_a_n = 1'b1, cs_b = 1'b0, bus_cd = 1'b0, stb0 = 1'b1, stb1 = 1'b1;
  logic [15:0] bus_din = '0, bus_dq_o, rd_rsp_data = '0, pix_data;
  logic bus_oe, addr_upd = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0, pix_valid, pix_ready = 1'b0;
  logic [7:0] cmd_data;
  logic rd_req_valid, mem_ready = 1'b1, rd_rsp_valid = 1'b0;

  hpb_port u_hpb_port (
    .clk(clk), .rst_n(rst_n), .cfg_mode68(cfg_mode68), .cfg_wide(cfg_wide),
    .bus_cs_a_n(cs_a_n), .bus_cs_b(cs_b), .bus_cd(bus_cd),
    .bus_stb0(stb0), .bus_stb1(stb1), .bus_din(bus_din),
    .bus_dq_o(bus_dq_o), .bus_oe(bus_oe), .addr_upd(addr_upd),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(mem_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  int n_chk = 0, n_fail = 0, fetch_cnt = 0;
  logic [15:0] next_word = 16'h1234, model_latch = 16'h0000;
  logic seen_oe;
  logic [15:0] seen_dq;

  // bench memory: answers each taken fetch at once with a counting word
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    if (rst_n && rd_req_valid && mem_ready) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = next_word;
      model_latch  = next_word;
      next_word    = next_word + 16'h0111;
      fetch_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    stb0 = 1'b1;
    stb1 = cfg_mode68 ? 1'b0 : 1'b1;
    cs_a_n = 1'b1;
    cs_b = 1'b0;
  endtask

  task automatic host(input bit rd, input bit cd, input logic [15:0] d,
                      input bit csa_ok, input bit csb_ok);
    @(negedge clk);
    bus_cd = cd; bus_din = d; cs_a_n = !csa_ok; cs_b = csb_ok;
    if (cfg_mode68) begin stb0 = rd; stb1 = 1'b1; end
    else if (rd) stb1 = 1'b0;
    else stb0 = 1'b0;
    repeat (3) @(negedge clk);
    seen_oe = bus_oe; seen_dq = bus_dq_o;
    @(negedge clk);
    if (cfg_mode68) stb1 = 1'b0; else begin stb0 = 1'b1; stb1 = 1'b1; end
    repeat (4) @(negedge clk);
    set_idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic take_cmd(); @(negedge clk); cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0; endtask
  task automatic take_pix(); @(negedge clk); pix_ready = 1'b1; @(negedge clk); pix_ready = 1'b0; endtask
  task automatic pulse_upd(); @(negedge clk); addr_upd = 1'b1; @(negedge clk); addr_upd = 1'b0; endtask

  task automatic mode(input bit m68, input bit wide);
    @(negedge clk);
    cfg_mode68 = m68; cfg_wide = wide;
    set_idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // {mode68, wide, cd, din[15:0], kind[1:0] (0 none,1 cmd,2 pix), expected[15:0]}
  localparam logic [36:0] VEC [9] = '{
    {1'b0, 1'b1, 1'b0, 16'h0036, 2'd1, 16'h0036},
    {1'b0, 1'b1, 1'b1, 16'hF00D, 2'd2, 16'hF00D},
    {1'b1, 1'b1, 1'b1, 16'h0BAD, 2'd2, 16'h0BAD},
    {1'b1, 1'b1, 1'b0, 16'h00A5, 2'd1, 16'h00A5},
    {1'b0, 1'b0, 1'b1, 16'hFFC3, 2'd0, 16'h0000},
    {1'b0, 1'b0, 1'b1, 16'h005A, 2'd2, 16'hC35A},
    {1'b1, 1'b0, 1'b1, 16'h0012, 2'd0, 16'h0000},
    {1'b1, 1'b0, 1'b1, 16'h0034, 2'd2, 16'h1234},
    {1'b1, 1'b0, 1'b0, 16'h9977, 2'd1, 16'h0077}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int f0;
    logic [15:0] w;
    set_idle();
    repeat (5) @(negedge clk);
    chk("R4 reset cmd_valid", {15'b0, cmd_valid}, 16'h0);
    chk("R4 reset pix_valid", {15'b0, pix_valid}, 16'h0);
    chk("R4 reset rd_req_valid", {15'b0, rd_req_valid}, 16'h0);
    chk("R11 reset bus_oe", {15'b0, bus_oe}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R1 R2 R5 R6 write decoding in both conventions and widths
    for (int i = 0; i < 9; i++) begin
      mode(VEC[i][36], VEC[i][35]);
      host(1'b0, VEC[i][34], VEC[i][33:18], 1'b1, 1'b1);
      chk("R11 no drive on write", {15'b0, seen_oe}, 16'h0);
      case (VEC[i][17:16])
        2'd1: begin
          chk("R6 cmd_valid", {15'b0, cmd_valid}, 16'h1);
          chk("R6 cmd_data", {8'h00, cmd_data}, VEC[i][15:0]);
          take_cmd();
        end
        2'd2: begin
          chk(VEC[i][36] ? "R2 pix_valid" : "R1 pix_valid", {15'b0, pix_valid}, 16'h1);
          chk("R5 pix_data", pix_data, VEC[i][15:0]);
          take_pix();
        end
        default: begin
          chk("R5 first byte holds", {14'b0, cmd_valid, pix_valid}, 16'h0);
        end
      endcase
    end

    // R3 select gating
    mode(1'b0, 1'b1);
    host(1'b0, 1'b1, 16'h5555, 1'b1, 1'b0);
    chk("R3 cs_b low ignored", {15'b0, pix_valid}, 16'h0);
    host(1'b0, 1'b1, 16'h6666, 1'b0, 1'b1);
    chk("R3 cs_a_n high ignored", {15'b0, pix_valid}, 16'h0);
    host(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);
    chk("R3 deselected read no drive", {15'b0, seen_oe}, 16'h0);

    // R8 drop while pending
    host(1'b0, 1'b1, 16'hBEEF, 1'b1, 1'b1);
    host(1'b0, 1'b1, 16'hCAFE, 1'b1, 1'b1);
    chk("R8 first word kept", pix_data, 16'hBEEF);
    chk("R8 still valid", {15'b0, pix_valid}, 16'h1);
    take_pix();
    chk("R8 cleared after ready", {15'b0, pix_valid}, 16'h0);

    // R7 phase restart on control cycle and on address pulse
    mode(1'b0, 1'b0);
    host(1'b0, 1'b1, 16'h00AA, 1'b1, 1'b1);
    host(1'b0, 1'b0, 16'h002C, 1'b1, 1'b1);
    chk("R7 cmd between bytes", {8'h00, cmd_data}, 16'h002C);
    take_cmd();
    host(1'b0, 1'b1, 16'h0011, 1'b1, 1'b1);
    host(1'b0, 1'b1, 16'h0022, 1'b1, 1'b1);
    chk("R7 restart after cmd", pix_data, 16'h1122);
    take_pix();
    host(1'b0, 1'b1, 16'h0033, 1'b1, 1'b1);
    pulse_upd();
    host(1'b0, 1'b1, 16'h0044, 1'b1, 1'b1);
    chk("R7 no word after upd", {15'b0, pix_valid}, 16'h0);
    host(1'b0, 1'b1, 16'h0055, 1'b1, 1'b1);
    chk("R7 restart after upd", pix_data, 16'h4455);
    take_pix();

    // R9 16-bit read pipeline with dummy read
    mode(1'b0, 1'b1);
    pulse_upd();
    f0 = fetch_cnt; w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R11 oe during read", {15'b0, seen_oe}, 16'h1);
    chk("R9 dummy returns stale", seen_dq, w);
    chk("R9 dummy fetches", fetch_cnt[15:0], f0[15:0] + 16'd1);
    w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R9 second read fresh", seen_dq, w);
    chk("R11 oe released", {15'b0, bus_oe}, 16'h0);
    mode(1'b1, 1'b1);
    w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R2 read via enable", seen_dq, w);
    chk("R12 latch loaded", model_latch, w + 16'h0111);

    // R11 control read
    f0 = fetch_cnt;
    host(1'b1, 1'b0, 16'h0, 1'b1, 1'b1);
    chk("R11 control read zero", seen_dq, 16'h0000);
    chk("R11 control read no fetch", fetch_cnt[15:0], f0[15:0]);

    // R10 byte reads
    mode(1'b0, 1'b0);
    pulse_upd();
    f0 = fetch_cnt; w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R9 byte dummy stale", seen_dq, {8'h00, w[15:8]});
    w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R10 high byte", seen_dq, {8'h00, w[15:8]});
    chk("R10 no fetch on high", fetch_cnt[15:0], f0[15:0] + 16'd1);
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R10 low byte", seen_dq, {8'h00, w[7:0]});
    chk("R10 fetch on low", fetch_cnt[15:0], f0[15:0] + 16'd2);
    w = model_latch;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    chk("R10 next high byte", seen_dq, {8'h00, w[15:8]});

    // R12 request held until ready
    mode(1'b0, 1'b1);
    mem_ready = 1'b0;
    f0 = fetch_cnt;
    host(1'b1, 1'b1, 16'h0, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk("R12 request held", {15'b0, rd_req_valid}, 16'h1);
    chk("R12 no fetch yet", fetch_cnt[15:0], f0[15:0]);
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 request taken", {15'b0, rd_req_valid}, 16'h0);
    chk("R12 one fetch", fetch_cnt[15:0], f0[15:0] + 16'd1);

    finish_run();
  end
endmodule